// File: doc/BRIEF.md
# Dual-slope conversion sequencer

This block is the digital timing and counting core of a 3.5-digit dual-slope integrating A/D converter. It runs from the oscillator clock and reads the output of an external comparator. It drives four switch controls for the analog front end, and exactly one of them is active at any time. The first connects the integrator for auto-zero. The second connects it for signal integrate. The other two connect it for de-integrate, one with the positive reference and one with the negative reference. A prescaler turns every `OSC_DIV` oscillator clocks into one count. Every conversion lasts exactly `CYCLE_COUNTS` counts, whatever the input.

A conversion runs through three states: `PH_AUTOZERO`, `PH_INTEGRATE` and `PH_DEINT`.
- **AZ_TO_INT** fires on the last count of the cycle and clears the decade counter.
- **INT_TO_DE** fires after `INT_COUNTS` counts. It samples the synchronized comparator as the polarity.
- **DE_TO_AZ** fires on the first count at which the synchronized comparator differs from that polarity, or when the count reaches `FULL_COUNTS`. On this transition the BCD tally, the polarity and the overrange flag are copied to the outputs.

Auto-zero takes whatever part of the cycle de-integrate leaves unused. After reset the block starts in `PH_AUTOZERO` at cycle position `INT_COUNTS+FULL_COUNTS+1`.

Top module: `dsadc_core`

## Requirements
- R1: While reset is asserted and right after it is released, only `sw_autozero_o` is high, `result_bcd_o` is zero, and `result_neg_o` and `result_ovr_o` are low.
- R2: In every clock cycle, exactly one of `sw_autozero_o`, `sw_integrate_o`, `sw_ref_pos_o` and `sw_ref_neg_o` is high.
- R3: One count lasts `OSC_DIV` clocks. `sw_integrate_o` stays high for exactly `INT_COUNTS*OSC_DIV` clocks in each conversion.
- R4: The switches follow the order auto-zero, integrate, de-integrate, auto-zero. Successive rising edges of `sw_integrate_o` are exactly `CYCLE_COUNTS*OSC_DIV` clocks apart, for any input.
- R5: The synchronized comparator is sampled on the last integrate count. If it is high (integrator above zero), de-integrate uses `sw_ref_neg_o` and the latched `result_neg_o` is 0. If it is low, de-integrate uses `sw_ref_pos_o` and `result_neg_o` is 1.
- R6: The comparator passes through a two-flop synchronizer. De-integrate ends on the first count at which the synchronized comparator differs from the sampled polarity. The result is the number of de-integrate counts completed before that count. The de-integrate switch stays high for (result+1)*`OSC_DIV` clocks.
- R7: `result_bcd_o` holds four BCD decades. Bits [3:0] are units, [7:4] tens, [11:8] hundreds and [15:12] thousands, and each digit is 0 to 9.
- R8: If the count reaches `FULL_COUNTS` with no crossing seen, de-integrate ends on the next count with result `FULL_COUNTS` and `result_ovr_o` = 1. Any conversion that ends on a crossing gives `result_ovr_o` = 0.
- R9: The three result outputs change only on the clock edge where de-integrate ends and `sw_autozero_o` rises. At all other times they are stable.
- R10: In steady state, auto-zero lasts `CYCLE_COUNTS-INT_COUNTS-(result+1)` counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator output, high when the integrator is above zero; asynchronous |
| sw_autozero_o | output | 1 | Auto-zero switch control |
| sw_integrate_o | output | 1 | Signal integrate switch control |
| sw_ref_pos_o | output | 1 | De-integrate with positive reference |
| sw_ref_neg_o | output | 1 | De-integrate with negative reference |
| result_bcd_o | output | 16 | Latched BCD count, four decades |
| result_neg_o | output | 1 | Latched polarity, 1 means negative input |
| result_ovr_o | output | 1 | Latched overrange flag |

## Verification
The bench builds the block with `OSC_DIV`=4, `INT_COUNTS`=100, `FULL_COUNTS`=200 and `CYCLE_COUNTS`=400. One conversion then takes 1600 clocks instead of 16000, so eight conversions of both polarities fit in a short run. The smaller values bring several corner cases within reach: a crossing on the very first de-integrate count, a crossing on the last count before the cap, and overrange in both polarities. They also bring carries across three decades and the extremes of auto-zero length. The comparator is scripted against the switch outputs, so each crossing lands on a chosen count behind the two-flop synchronizer.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        PH_AUTOZERO  = 2'd0,
        PH_INTEGRATE = 2'd1,
        PH_DEINT     = 2'd2
    } phase_e;

    localparam int BCD_W = 4;
endpackage

// File: rtl/dsadc_prescaler.sv
module dsadc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    generate
        if (DIV > 1) begin : g_div
            localparam int W = $clog2(DIV);
            logic [W-1:0] cnt_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cnt_q <= '0;
                end else if (cnt_q == W'(DIV - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = (cnt_q == W'(DIV - 1));

            // R3: a count never lasts a single clock when the divider exceeds one
            assert_tick_spacing_R3: assert property (
                @(posedge clk_i) disable iff (!rst_ni) tick_o |=> !tick_o)
                else $error("tick repeated on consecutive clocks");
        end else begin : g_pass
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter
    import dsadc_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic                    inc_i,
    output logic [BCD_W*DIGITS-1:0] bcd_o
);
    logic [DIGITS:0] carry;

    assign carry[0] = inc_i;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_decade
            logic [BCD_W-1:0] digit_q;
            logic             wrap;

            assign wrap         = (digit_q == 4'd9);
            assign carry[g+1]   = carry[g] && wrap;
            assign bcd_o[BCD_W*g +: BCD_W] = digit_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    digit_q <= '0;
                end else if (clr_i) begin
                    digit_q <= '0;
                end else if (carry[g]) begin
                    digit_q <= wrap ? 4'd0 : digit_q + 4'd1;
                end
            end

            // R7: every decade stays a legal BCD digit
            assert_digit_range_R7: assert property (
                @(posedge clk_i) disable iff (!rst_ni) digit_q <= 4'd9)
                else $error("decade left BCD range");
        end
    endgenerate

    logic unused_top_carry;
    assign unused_top_carry = carry[DIGITS];
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
    import dsadc_pkg::*;
#(
    parameter int INT_COUNTS   = 1000,
    parameter int FULL_COUNTS  = 2000,
    parameter int CYCLE_COUNTS = 4000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic cmp_sync_i,
    output logic sw_autozero_o,
    output logic sw_integrate_o,
    output logic sw_ref_pos_o,
    output logic sw_ref_neg_o,
    output logic cnt_clr_o,
    output logic cnt_inc_o,
    output logic latch_o,
    output logic latch_ovr_o,
    output logic pol_neg_o
);
    localparam int PW        = $clog2(CYCLE_COUNTS);
    localparam int DW        = $clog2(FULL_COUNTS + 1);
    localparam int RESET_POS = INT_COUNTS + FULL_COUNTS + 1;

    phase_e        state_q, state_d;
    logic [PW-1:0] pos_q;
    logic [DW-1:0] de_q;
    logic          pol_hi_q;

    logic at_cycle_end, at_int_end, crossing, de_cap;

    assign at_cycle_end = (pos_q == PW'(CYCLE_COUNTS - 1));
    assign at_int_end   = (pos_q == PW'(INT_COUNTS - 1));
    assign crossing     = (cmp_sync_i != pol_hi_q);
    assign de_cap       = (de_q == DW'(FULL_COUNTS));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_AUTOZERO:  if (tick_i && at_cycle_end)          state_d = PH_INTEGRATE;
            PH_INTEGRATE: if (tick_i && at_int_end)            state_d = PH_DEINT;
            PH_DEINT:     if (tick_i && (crossing || de_cap))  state_d = PH_AUTOZERO;
            default:                                           state_d = PH_AUTOZERO;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= PH_AUTOZERO;
            pos_q    <= PW'(RESET_POS);
            de_q     <= '0;
            pol_hi_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (tick_i) begin
                pos_q <= at_cycle_end ? '0 : pos_q + 1'b1;
            end
            if (cnt_clr_o) begin
                de_q <= '0;
            end else if (cnt_inc_o) begin
                de_q <= de_q + 1'b1;
            end
            if (tick_i && state_q == PH_INTEGRATE && at_int_end) begin
                pol_hi_q <= cmp_sync_i;
            end
        end
    end

    // outputs
    always_comb begin
        sw_autozero_o  = 1'b0;
        sw_integrate_o = 1'b0;
        sw_ref_pos_o   = 1'b0;
        sw_ref_neg_o   = 1'b0;
        cnt_clr_o      = 1'b0;
        cnt_inc_o      = 1'b0;
        latch_o        = 1'b0;
        latch_ovr_o    = 1'b0;
        unique case (state_q)
            PH_AUTOZERO: begin
                sw_autozero_o = 1'b1;
                cnt_clr_o     = tick_i && at_cycle_end;
            end
            PH_INTEGRATE: begin
                sw_integrate_o = 1'b1;
            end
            PH_DEINT: begin
                sw_ref_neg_o = pol_hi_q;
                sw_ref_pos_o = !pol_hi_q;
                cnt_inc_o    = tick_i && !crossing && !de_cap;
                latch_o      = tick_i && (crossing || de_cap);
                latch_ovr_o  = de_cap && !crossing;
            end
            default: begin
                sw_autozero_o = 1'b1;
            end
        endcase
    end

    assign pol_neg_o = !pol_hi_q;

    // R2: the front end never sees two switches, or none
    assert_switch_onehot_R2: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        $onehot({sw_autozero_o, sw_integrate_o, sw_ref_pos_o, sw_ref_neg_o}))
        else $error("switch controls not one-hot");

    // R3: integrate is confined to the first INT_COUNTS positions of the cycle
    assert_integrate_window_R3: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (state_q == PH_INTEGRATE) |-> (pos_q < PW'(INT_COUNTS)))
        else $error("integrate outside its window");

    // R4: de-integrate is only left towards auto-zero
    assert_order_de_R4: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (state_q == PH_DEINT) |=> (state_q != PH_INTEGRATE))
        else $error("de-integrate jumped to integrate");

    // R4: auto-zero never skips integrate
    assert_order_az_R4: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (state_q == PH_AUTOZERO) |=> (state_q != PH_DEINT))
        else $error("auto-zero jumped to de-integrate");

    // R5: the sampled polarity is held through de-integrate
    assert_pol_held_R5: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (state_q == PH_DEINT && $past(state_q) == PH_DEINT) |-> $stable(pol_hi_q))
        else $error("polarity changed during de-integrate");

    // R8: the de-integrate tally never passes full scale
    assert_no_overflow_R8: assert property (
        @(posedge clk_i) disable iff (!rst_ni) de_q <= DW'(FULL_COUNTS))
        else $error("de-integrate tally past full scale");
endmodule

// File: rtl/dsadc_core.sv
module dsadc_core
    import dsadc_pkg::*;
#(
    parameter int OSC_DIV      = 4,
    parameter int INT_COUNTS   = 1000,
    parameter int FULL_COUNTS  = 2000,
    parameter int CYCLE_COUNTS = 4000,
    parameter int DIGITS       = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    cmp_i,
    output logic                    sw_autozero_o,
    output logic                    sw_integrate_o,
    output logic                    sw_ref_pos_o,
    output logic                    sw_ref_neg_o,
    output logic [BCD_W*DIGITS-1:0] result_bcd_o,
    output logic                    result_neg_o,
    output logic                    result_ovr_o
);
    localparam int RW = BCD_W * DIGITS;

    logic          tick, cmp_sync;
    logic          cnt_clr, cnt_inc, latch_en, latch_ovr, pol_neg;
    logic [RW-1:0] tally_bcd;

    dsadc_prescaler #(.DIV(OSC_DIV)) u_prescaler (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (cmp_i),
        .q_o   (cmp_sync)
    );

    dsadc_sequencer #(
        .INT_COUNTS  (INT_COUNTS),
        .FULL_COUNTS (FULL_COUNTS),
        .CYCLE_COUNTS(CYCLE_COUNTS)
    ) u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick),
        .cmp_sync_i    (cmp_sync),
        .sw_autozero_o (sw_autozero_o),
        .sw_integrate_o(sw_integrate_o),
        .sw_ref_pos_o  (sw_ref_pos_o),
        .sw_ref_neg_o  (sw_ref_neg_o),
        .cnt_clr_o     (cnt_clr),
        .cnt_inc_o     (cnt_inc),
        .latch_o       (latch_en),
        .latch_ovr_o   (latch_ovr),
        .pol_neg_o     (pol_neg)
    );

    dsadc_bcd_counter #(.DIGITS(DIGITS)) u_tally (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .bcd_o (tally_bcd)
    );

    // output latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_bcd_o <= '0;
            result_neg_o <= 1'b0;
            result_ovr_o <= 1'b0;
        end else if (latch_en) begin
            result_bcd_o <= tally_bcd;
            result_neg_o <= pol_neg;
            result_ovr_o <= latch_ovr;
        end
    end

    // R9: results move only when a conversion completes
    assert_result_hold_R9: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !latch_en |=> $stable({result_bcd_o, result_neg_o, result_ovr_o}))
        else $error("result changed outside a latch");

    // R9: the latch coincides with the return to auto-zero
    assert_latch_to_az_R9: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        latch_en |=> sw_autozero_o)
        else $error("latch not followed by auto-zero");
endmodule

// File: tb/dsadc_core_tb_top.sv
module dsadc_core_tb_top;
    localparam int P  = 4;
    localparam int NI = 100;
    localparam int NF = 200;
    localparam int NC = 400;
    localparam int ND = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp = 1'b0;
    logic sw_az, sw_int, sw_rp, sw_rn;
    logic [4*ND-1:0] res_bcd;
    logic res_neg, res_ovr;

    always #4 clk = ~clk;

    dsadc_core #(
        .OSC_DIV(P), .INT_COUNTS(NI), .FULL_COUNTS(NF),
        .CYCLE_COUNTS(NC), .DIGITS(ND), .SYNC_STAGES(2)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp),
        .sw_autozero_o(sw_az), .sw_integrate_o(sw_int),
        .sw_ref_pos_o(sw_rp), .sw_ref_neg_o(sw_rn),
        .result_bcd_o(res_bcd), .result_neg_o(res_neg), .result_ovr_o(res_ovr)
    );

    typedef struct {
        int k;
        bit neg;
        bit ovr;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;
    int   onehot_viol = 0;
    int   stable_viol = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [4*ND-1:0] to_bcd(input int v);
        logic [4*ND-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < ND; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // monitor / scoreboard
    logic p_az = 1'b1, p_int = 1'b0, p_de = 1'b0;
    logic [4*ND+1:0] p_res = '0;
    int int_len = 0, de_len = 0, az_len = 0, period = 0, last_k = 0;
    bit have_period = 0, have_az = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            logic de_now;
            de_now = sw_rp || sw_rn;
            if ($countones({sw_az, sw_int, sw_rp, sw_rn}) != 1) onehot_viol++;
            if ({res_bcd, res_neg, res_ovr} != p_res && !(sw_az && !p_az)) stable_viol++;

            if (sw_int && !p_int) begin
                if (have_az)
                    chk(az_len == (NC - NI - (last_k + 1)) * P, "R10", "auto-zero clocks",
                        az_len, (NC - NI - (last_k + 1)) * P);
                if (have_period)
                    chk(period == NC * P, "R4", "conversion period", period, NC * P);
                have_period = 1;
                period = 0;
                int_len = 0;
            end
            if (de_now && !p_de) begin
                chk(p_int, "R4", "de-integrate follows integrate", int'(p_int), 1);
                chk(int_len == NI * P, "R3", "integrate clocks", int_len, NI * P);
                if (exp_q.size() > 0)
                    chk(sw_rp == exp_q[0].neg, "R5", "positive reference selected",
                        int'(sw_rp), int'(exp_q[0].neg));
                de_len = 0;
            end
            if (sw_az && !p_az) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected result", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(res_bcd == to_bcd(e.k), "R7", "bcd result",
                        int'(res_bcd), int'(to_bcd(e.k)));
                    chk(res_neg == e.neg, "R5", "polarity", int'(res_neg), int'(e.neg));
                    chk(res_ovr == e.ovr, "R8", "overrange", int'(res_ovr), int'(e.ovr));
                    chk(de_len == (e.k + 1) * P, "R6", "de-integrate clocks",
                        de_len, (e.k + 1) * P);
                    last_k = e.k;
                    have_az = 1;
                end
                az_len = 0;
            end

            if (sw_int) int_len++;
            if (de_now) de_len++;
            if (sw_az) az_len++;
            period++;
            p_az = sw_az;
            p_int = sw_int;
            p_de = de_now;
            p_res = {res_bcd, res_neg, res_ovr};
        end
    end

    // driver: one conversion with a scripted comparator
    task automatic run_conv(input int k, input bit neg, input bit ovr);
        exp_t e;
        do @(negedge clk); while (!sw_int);
        cmp = !neg;
        e.k = ovr ? NF : k;
        e.neg = neg;
        e.ovr = ovr;
        exp_q.push_back(e);
        do @(negedge clk); while (!(sw_rp || sw_rn));
        if (!ovr) begin
            repeat ((k + 1) * P - 3) @(posedge clk);
            @(negedge clk);
            cmp = neg;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk(sw_az && !sw_int && !sw_rp && !sw_rn, "R1", "switches in reset",
            int'({sw_az, sw_int, sw_rp, sw_rn}), 8);
        chk(res_bcd == '0 && !res_neg && !res_ovr, "R1", "result in reset",
            int'({res_bcd, res_neg, res_ovr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sw_az && !sw_int && !sw_rp && !sw_rn, "R1", "switches after release",
            int'({sw_az, sw_int, sw_rp, sw_rn}), 8);

        run_conv(37, 1'b0, 1'b0);
        run_conv(123, 1'b1, 1'b0);
        run_conv(0, 1'b0, 1'b0);
        run_conv(NF - 1, 1'b1, 1'b0);
        run_conv(0, 1'b0, 1'b1);
        run_conv(0, 1'b1, 1'b1);
        run_conv(150, 1'b0, 1'b0);
        run_conv(9, 1'b1, 1'b0);

        do @(negedge clk); while (!sw_int);
        repeat (2) @(negedge clk);

        chk(exp_q.size() == 0, "R6", "results outstanding", exp_q.size(), 0);
        chk(onehot_viol == 0, "R2", "one-hot violations", onehot_viol, 0);
        chk(stable_viol == 0, "R9", "result changes outside latch", stable_viol, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule